// File: doc/BRIEF.md
# Registered-Select Bus Multiplexer/Demultiplexer

This block joins one 16-bit port A with two 16-bit ports, B1 and B2. A 2-bit connection code is held in a register. The register loads on a rising clock edge only while an active-low load enable is asserted. In the A-to-B direction the registered code routes A to B1, to B2, to both, or to neither. In the B-to-A direction it selects one B port onto A.

A logic block cannot model a true bidirectional pass switch. A direction input therefore chooses which side drives. Every output port has a per-bit output enable, so the pad logic around it can tri-state any port that is not driven. The path from the register to the enables is a single two-bit decode, which keeps it short enough for a fast clock.

Top module: `regsel_busswitch`

## Requirements
- R1: A synchronous active-high reset sets the registered code to 00, so after reset every output enable is low.
- R2: A new code is loaded from `conn_sel` only at a rising clock edge where `load_n` is low. A change on `conn_sel` between edges does not change the outputs.
- R3: While `load_n` is high, the registered code keeps its value through any number of clock edges, whatever `conn_sel` shows.
- R4: Code 00 drives no port in either direction: `a_oe`, `b1_oe` and `b2_oe` are all zero.
- R5: With `dir` = 0 and code 01, `b1_out` and `b2_out` both equal `a_in`, and `b1_oe` and `b2_oe` are all ones.
- R6: With `dir` = 0, code 10 drives only B1 from A and code 11 drives only B2 from A.
- R7: With `dir` = 1, code 10 or 01 puts `b1_in` on `a_out`, and code 11 puts `b2_in` on `a_out`. Under 01, B1 wins over B2. `a_oe` is all ones for any non-zero code.
- R8: The two directions never drive at once. When `dir` = 0, `a_oe` is zero. When `dir` = 1, `b1_oe` and `b2_oe` are zero.
- R9: The data output of any port whose enable is low reads all zeros.
- R10: A change on `dir` takes effect on the outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the code register |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low load enable for the code register |
| conn_sel | input | 2 | Connection code: 00 off, 01 both, 10 B1, 11 B2 |
| dir | input | 1 | 0 = A drives B side, 1 = B side drives A |
| a_in | input | 16 | Data arriving at port A |
| b1_in | input | 16 | Data arriving at port B1 |
| b2_in | input | 16 | Data arriving at port B2 |
| a_out | output | 16 | Data driven onto port A |
| a_oe | output | 16 | Per-bit output enable for port A |
| b1_out | output | 16 | Data driven onto port B1 |
| b1_oe | output | 16 | Per-bit output enable for port B1 |
| b2_out | output | 16 | Data driven onto port B2 |
| b2_oe | output | 16 | Per-bit output enable for port B2 |

## Verification
All four codes are tried in both directions.

- **Distinct words:** `a_in`, `b1_in` and `b2_in` carry different words, so a wrong source selection or a swapped B port shows up in the data.
- **Equal B words:** a second pattern sets the two B inputs equal, and then complementary. The complementary case separates the B1-over-B2 priority under code 01 from a bitwise OR of both sources.
- **Load enable:** code changes are applied with `load_n` high, and also between edges with `load_n` low. These expose a register that ignores the enable or loads without an edge.
- **Direction:** flipping `dir` with no clock edge shows whether direction is wrongly registered.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_BOTH = 2'b01,
    SEL_B1   = 2'b10,
    SEL_B2   = 2'b11
  } sel_t;

  localparam int unsigned NUM_B = 2;

  typedef struct packed {
    logic [NUM_B-1:0] to_b;    // A drives B[i]
    logic [NUM_B-1:0] from_b;  // B[i] drives A (one-hot or zero)
  } route_t;

  // Single-level decode of the registered code and the direction.
  function automatic route_t decode_route(input sel_t s, input logic dir);
    route_t r;
    r.to_b   = '0;
    r.from_b = '0;
    if (!dir) begin
      case (s)
        SEL_BOTH: r.to_b = 2'b11;
        SEL_B1:   r.to_b = 2'b01;
        SEL_B2:   r.to_b = 2'b10;
        default:  r.to_b = 2'b00;
      endcase
    end else begin
      case (s)
        SEL_BOTH, SEL_B1: r.from_b = 2'b01;  // B1 has priority
        SEL_B2:           r.from_b = 2'b10;
        default:          r.from_b = 2'b00;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bsw_sel_reg.sv
module bsw_sel_reg
  import bsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_n,
  input  logic [1:0] sel_d,
  output sel_t       sel_q
);

  logic do_load;
  assign do_load = !load_n;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= SEL_OFF;
    else if (do_load)
      sel_q <= sel_t'(sel_d);
  end

  p_reset_off_r1: assert property (@(posedge clk) rst |=> sel_q == SEL_OFF)
    else $error("sel_q not cleared by reset");

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    do_load |=> sel_q == sel_t'($past(sel_d)))
    else $error("code not loaded");

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !do_load |=> $stable(sel_q))
    else $error("code changed without load");

endmodule

// File: rtl/bsw_router.sv
module bsw_router
  import bsw_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  sel_t                    sel_q,
  input  logic                    dir,
  input  logic [W-1:0]            a_in,
  input  logic [NUM_B-1:0][W-1:0] b_in,
  output logic [W-1:0]            a_out,
  output logic [W-1:0]            a_oe,
  output logic [NUM_B-1:0][W-1:0] b_out,
  output logic [NUM_B-1:0][W-1:0] b_oe
);

  route_t           route;
  logic             a_drv;
  logic [NUM_B-1:0] b_drv;

  assign route = decode_route(sel_q, dir);
  assign a_drv = |route.from_b;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_B; gi++) begin : g_bport
      assign b_drv[gi] = route.to_b[gi];
      assign b_out[gi] = b_drv[gi] ? a_in : '0;
      assign b_oe[gi]  = {W{b_drv[gi]}};
    end
  endgenerate

  always_comb begin
    a_out = '0;
    for (int i = NUM_B - 1; i >= 0; i--) begin
      if (route.from_b[i]) a_out = b_in[i];
    end
  end

  assign a_oe = {W{a_drv}};

  p_dir_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(a_drv && (|b_drv)))
    else $error("both directions driving");

  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_OFF) |-> (a_oe == '0 && b_oe == '0))
    else $error("port driven with code 00");

  p_prio_r7: assert property (@(posedge clk) disable iff (rst)
    (dir && sel_q == SEL_BOTH) |-> a_out == b_in[0])
    else $error("B1 priority lost");

  p_from_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(route.from_b))
    else $error("more than one B source");

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) |-> (a_out == '0))
    else $error("undriven A not zero");

endmodule

// File: rtl/regsel_busswitch.sv
module regsel_busswitch
  import bsw_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [1:0]   conn_sel,
  input  logic         dir,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b1_in,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b1_out,
  output logic [W-1:0] b1_oe,
  output logic [W-1:0] b2_out,
  output logic [W-1:0] b2_oe
);

  sel_t                    sel_q;
  logic [NUM_B-1:0][W-1:0] b_in_pk;
  logic [NUM_B-1:0][W-1:0] b_out_pk;
  logic [NUM_B-1:0][W-1:0] b_oe_pk;

  assign b_in_pk[0] = b1_in;
  assign b_in_pk[1] = b2_in;

  bsw_sel_reg u_sel (
    .clk    (clk),
    .rst    (rst),
    .load_n (load_n),
    .sel_d  (conn_sel),
    .sel_q  (sel_q)
  );

  bsw_router #(.W(W)) u_route (
    .clk   (clk),
    .rst   (rst),
    .sel_q (sel_q),
    .dir   (dir),
    .a_in  (a_in),
    .b_in  (b_in_pk),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_out (b_out_pk),
    .b_oe  (b_oe_pk)
  );

  assign b1_out = b_out_pk[0];
  assign b2_out = b_out_pk[1];
  assign b1_oe  = b_oe_pk[0];
  assign b2_oe  = b_oe_pk[1];

  p_b_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (b1_oe == '0 |-> b1_out == '0) and (b2_oe == '0 |-> b2_out == '0))
    else $error("undriven B port not zero");

endmodule

// File: tb/regsel_busswitch_tb.sv
`timescale 1ns/1ps
module regsel_busswitch_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_n = 1'b1;
  logic [1:0]   conn_sel = 2'b00;
  logic         dir = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  regsel_busswitch #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .load_n(load_n), .conn_sel(conn_sel), .dir(dir),
    .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_out(b2_out), .b2_oe(b2_oe)
  );

  // Compare all six outputs against the model for code s.
  task automatic check_code(input logic [1:0] s, input string req);
    logic e_b1, e_b2, e_a;
    logic [W-1:0] ea, eb1, eb2;
    logic [6*W-1:0] got, exp;
    e_b1 = (dir == 1'b0) && (s == 2'b01 || s == 2'b10);
    e_b2 = (dir == 1'b0) && (s == 2'b01 || s == 2'b11);
    e_a  = (dir == 1'b1) && (s != 2'b00);
    if (!e_a)              ea = '0;
    else if (s == 2'b11)   ea = b2_in;
    else                   ea = b1_in;
    eb1 = e_b1 ? a_in : '0;
    eb2 = e_b2 ? a_in : '0;
    exp = {ea, {W{e_a}}, eb1, {W{e_b1}}, eb2, {W{e_b2}}};
    got = {a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s code=%b dir=%b actual=%h expected=%h", req, s, dir, got, exp);
    end
  endtask

  function automatic string tag_for(input logic [1:0] s, input logic d);
    if (s == 2'b00) return "R4 R8 R9";
    if (d)          return "R7 R8 R9";
    if (s == 2'b01) return "R5 R8 R9";
    return "R6 R8 R9";
  endfunction

  // Load code at the next rising edge, then drop the enable and scramble.
  task automatic load_code(input logic [1:0] s);
    @(negedge clk);
    load_n = 1'b0; conn_sel = s;
    @(negedge clk);
    load_n = 1'b1; conn_sel = ~s;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    dir = 1'b0; check_code(2'b00, "R1");
    dir = 1'b1; #1; check_code(2'b00, "R1");
    @(negedge clk); rst = 1'b0; dir = 1'b0; #1;
  endtask

  task automatic t_all_codes(input logic d, input logic [W-1:0] pa,
                             input logic [W-1:0] p1, input logic [W-1:0] p2);
    a_in = pa; b1_in = p1; b2_in = p2;
    for (int k = 0; k < 4; k++) begin
      load_code(k[1:0]);
      dir = d; #1;
      check_code(k[1:0], tag_for(k[1:0], d));
    end
  endtask

  task automatic t_hold();
    dir = 1'b0; a_in = 16'h5A3C; b1_in = 16'h1111; b2_in = 16'h2222;
    load_code(2'b10);
    @(negedge clk); load_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      conn_sel = k[1:0];
      @(negedge clk); #1;
      check_code(2'b10, "R3");
    end
  endtask

  task automatic t_edge_only();
    dir = 1'b1; b1_in = 16'hAAAA; b2_in = 16'h5555;
    load_code(2'b11);
    @(negedge clk);
    load_n = 1'b0; conn_sel = 2'b10; #1;
    check_code(2'b11, "R2");          // no edge yet
    @(negedge clk); load_n = 1'b1; #1;
    check_code(2'b10, "R2");          // loaded at edge
  endtask

  task automatic t_dir_flip();
    a_in = 16'hC0DE; b1_in = 16'h0F0F; b2_in = 16'hF0F0;
    load_code(2'b01);
    @(negedge clk); #1;
    dir = 1'b0; #0.5; check_code(2'b01, "R10");
    dir = 1'b1; #0.5; check_code(2'b01, "R10");
    dir = 1'b0; #0.5; check_code(2'b01, "R10");
  endtask

  task automatic t_reset_midrun();
    dir = 1'b0; load_code(2'b01);
    @(negedge clk); rst = 1'b1; load_n = 1'b0; conn_sel = 2'b11;
    @(negedge clk); #1;
    check_code(2'b00, "R1");
    rst = 1'b0; load_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_all_codes(1'b0, 16'hBEEF, 16'h1234, 16'h5678);
    t_all_codes(1'b0, 16'h0001, 16'hFFFF, 16'h0000);
    t_all_codes(1'b1, 16'hBEEF, 16'h1234, 16'h5678);
    t_all_codes(1'b1, 16'h0000, 16'h00FF, 16'hFF00);
    t_all_codes(1'b1, 16'h7777, 16'h3C3C, 16'h3C3C);
    t_hold();
    t_edge_only();
    t_dir_flip();
    t_reset_midrun();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule